// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block runs a multi-channel delta-sigma converter that sits on an SPI link in mode 1, from the host side. After power-up it puts the converter into a known state. It does this either by holding an active-low reset line low for a fixed number of clocks or by sending the one-byte reset command. The choice is set by a parameter.

After that it waits for a trigger that comes with a channel-enable mask. It visits the enabled channels in ascending index order. For each channel it runs a fixed sequence of four command frames: select the input through the multiplexer register, start, read, stop. Each 24-bit reading is stored in the next free 32-bit slot of a scan buffer.

When every enabled channel has been stored, the packed buffer is copied to the result port and a one-cycle valid strobe is raised. A busy flag covers both the boot phase and each scan. A trigger that arrives while the flag is high has no effect.

Top module: `adc_scan_seq`

## Requirements
- R1: With USE_RST_PIN=1, `adc_rst_no` is low from reset. It stays low for RST_LOW_CYC sampled cycles after the first rising clock edge that follows `rst_ni` release, and then goes high. `busy_o` is high and `spi_cs_no` stays high during that time.
- R2: With USE_RST_PIN=0, `adc_rst_no` stays high. The first SPI frame after reset is the single byte 0x06.
- R3: Enabled channels are converted lowest index first. The k-th converted channel lands in slot k, which is bits [32k+31:32k] of `res_data_o`. Slots that are not used read zero.
- R4: Each enabled channel ch produces exactly four frames, in this order: a 3-byte frame 0x42 0x00 ch (write of multiplexer register 0x02), a 1-byte frame 0x08 (start), a 4-byte frame 0x12 0x00 0x00 0x00 (read), and a 1-byte frame 0x0A (stop).
- R5: A slot holds the three bytes that the device returns after the read opcode. They are joined most significant byte first and zero-extended to 32 bits.
- R6: The SPI link uses mode 1 and sends the most significant bit first. `spi_sclk_o` idles low whenever `spi_cs_no` is high. MOSI changes only on SCLK rising edges, and MISO is captured on SCLK falling edges.
- R7: Between two frames, `spi_cs_no` stays high for at least CS_GAP clock cycles.
- R8: `res_valid_o` pulses for one cycle once per scan. `res_data_o` keeps its value until the next pulse.
- R9: A trigger seen while `busy_o` is high is ignored. This covers the boot phase and a running scan.
- R10: `busy_o` is low in the cycle where `res_valid_o` is high. A trigger in that cycle starts a new scan.
- R11: A trigger with an all-zero mask produces no SPI frame. It yields a valid pulse with all-zero data.
- R12: `busy_o` goes high in the cycle after an accepted trigger. It stays high until the cycle of the valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scan_mask_i | input | NUM_CH | Channel enable mask, sampled with the trigger |
| scan_trig_i | input | 1 | Scan request, accepted only while idle |
| busy_o | output | 1 | Boot or scan in progress |
| spi_sclk_o | output | 1 | SPI clock, idle low |
| spi_mosi_o | output | 1 | Serial data to the converter |
| spi_miso_i | input | 1 | Serial data from the converter |
| spi_cs_no | output | 1 | Chip select, active low |
| adc_rst_no | output | 1 | Converter reset line, active low |
| res_data_o | output | 32*NUM_CH | Packed scan results, slot 0 in the low bits |
| res_valid_o | output | 1 | One-cycle result strobe |

## Verification
The end of one scan and the request for the next can fall in the same cycle. The bench watches for the valid strobe and raises the trigger in that same cycle. It then expects `busy_o` to be high one cycle later and a second, correct result built from the new mask. A trigger pulsed in the middle of a scan, and one held during boot, must leave both the frame log and the result unchanged, with no extra valid strobe. Results are compared slot by slot against values that a bench-side converter model returns for each multiplexer selection.

// File: rtl/adc_scan_pkg.sv
`timescale 1ns/1ps
package adc_scan_pkg;
  localparam logic [7:0] OP_NOP   = 8'h00;
  localparam logic [7:0] OP_RESET = 8'h06;
  localparam logic [7:0] OP_START = 8'h08;
  localparam logic [7:0] OP_STOP  = 8'h0A;
  localparam logic [7:0] OP_RDATA = 8'h12;
  localparam logic [7:0] OP_WREG  = 8'h40;
  localparam logic [7:0] REG_MUX  = 8'h02;

  typedef enum logic [2:0] {
    E_IDLE, E_LEAD, E_HI, E_LO, E_TAIL, E_GAP
  } eng_state_e;

  typedef enum logic [2:0] {
    S_RPIN, S_RCMD, S_IDLE, S_NEXT, S_MUX, S_GO, S_RD, S_HALT
  } scan_state_e;
endpackage

// File: rtl/adc_chan_pick.sv
`timescale 1ns/1ps
module adc_chan_pick #(
  parameter int NUM_CH = 12,
  parameter int CH_W   = 4
) (
  input  logic [NUM_CH-1:0] mask_i,
  output logic              found_o,
  output logic [CH_W-1:0]   idx_o
);
  // lowest set bit wins
  always_comb begin
    found_o = |mask_i;
    idx_o   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = CH_W'(i);
    end
  end
endmodule

// File: rtl/adc_spi_frame_eng.sv
`timescale 1ns/1ps
module adc_spi_frame_eng
  import adc_scan_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int CS_GAP  = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [2:0]  len_i,
  input  logic [31:0] tx_i,
  output logic        done_o,
  output logic [23:0] rx_o,
  output logic        sclk_o,
  output logic        mosi_o,
  output logic        cs_no,
  input  logic        miso_i
);
  localparam int CNT_MAX = (CLK_DIV > CS_GAP) ? CLK_DIV : CS_GAP;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int GAP_W   = $clog2(CS_GAP + 1);
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(CLK_DIV - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(CS_GAP - 1);

  eng_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      sh_q;
  logic [5:0]       bits_q;
  logic [23:0]      rx_q;
  logic             sclk_q, mosi_q, cs_q;
  logic             div_hit, gap_hit;

  assign div_hit = (cnt_q == DIV_LAST);
  assign gap_hit = (cnt_q == GAP_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= E_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      bits_q <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      case (st_q)
        E_IDLE: if (start_i) begin
          sh_q   <= tx_i;
          bits_q <= {len_i, 3'b000};
          cs_q   <= 1'b0;
          cnt_q  <= '0;
          st_q   <= E_LEAD;
        end
        E_LEAD, E_LO: if (div_hit) begin
          cnt_q  <= '0;
          sclk_q <= 1'b1;
          mosi_q <= sh_q[31];
          sh_q   <= {sh_q[30:0], 1'b0};
          st_q   <= E_HI;
        end else cnt_q <= cnt_q + 1'b1;
        E_HI: if (div_hit) begin
          cnt_q  <= '0;
          sclk_q <= 1'b0;
          rx_q   <= {rx_q[22:0], miso_i};
          bits_q <= bits_q - 1'b1;
          st_q   <= (bits_q == 6'd1) ? E_TAIL : E_LO;
        end else cnt_q <= cnt_q + 1'b1;
        E_TAIL: if (div_hit) begin
          cnt_q <= '0;
          cs_q  <= 1'b1;
          st_q  <= E_GAP;
        end else cnt_q <= cnt_q + 1'b1;
        E_GAP: if (gap_hit) begin
          cnt_q <= '0;
          st_q  <= E_IDLE;
        end else cnt_q <= cnt_q + 1'b1;
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign done_o = (st_q == E_GAP) && gap_hit;
  assign rx_o   = rx_q;
  assign sclk_o = sclk_q;
  assign mosi_o = mosi_q;
  assign cs_no  = cs_q;

  // saturating count of chip-select high cycles, for the gap check
  logic [GAP_W-1:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt_q <= GAP_W'(CS_GAP);
    else if (!cs_q) hi_cnt_q <= '0;
    else if (hi_cnt_q != GAP_W'(CS_GAP)) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  a_r7_cs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_cnt_q == GAP_W'(CS_GAP)));
  a_r6_sclk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  a_r6_mosi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> $stable(mosi_o));
endmodule

// File: rtl/adc_scan_seq.sv
`timescale 1ns/1ps
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH      = 12,
  parameter int CLK_DIV     = 2,
  parameter int CS_GAP      = 4,
  parameter int RST_LOW_CYC = 40000,
  parameter bit USE_RST_PIN = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CH-1:0]    scan_mask_i,
  input  logic                 scan_trig_i,
  output logic                 busy_o,
  output logic                 spi_sclk_o,
  output logic                 spi_mosi_o,
  input  logic                 spi_miso_i,
  output logic                 spi_cs_no,
  output logic                 adc_rst_no,
  output logic [32*NUM_CH-1:0] res_data_o,
  output logic                 res_valid_o
);
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SLOT_W = $clog2(NUM_CH + 1);
  localparam int RCNT_W = $clog2(RST_LOW_CYC + 1);

  scan_state_e        state_q;
  logic [NUM_CH-1:0]  mask_q;
  logic [CH_W-1:0]    cur_ch_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [RCNT_W-1:0]  rcnt_q;
  logic               pin_q, valid_q, launched_q;

  logic               pick_found;
  logic [CH_W-1:0]    pick_idx;
  logic               eng_start, eng_done, is_xfer;
  logic [2:0]         eng_len;
  logic [31:0]        eng_tx;
  logic [23:0]        eng_rx;
  logic               accept, store, frame_end;

  adc_chan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
    .mask_i (mask_q),
    .found_o(pick_found),
    .idx_o  (pick_idx)
  );

  adc_spi_frame_eng #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) u_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(eng_start),
    .len_i  (eng_len),
    .tx_i   (eng_tx),
    .done_o (eng_done),
    .rx_o   (eng_rx),
    .sclk_o (spi_sclk_o),
    .mosi_o (spi_mosi_o),
    .cs_no  (spi_cs_no),
    .miso_i (spi_miso_i)
  );

  always_comb begin
    is_xfer = 1'b1;
    eng_len = 3'd1;
    eng_tx  = '0;
    case (state_q)
      S_RCMD: eng_tx = {OP_RESET, 24'h0};
      S_MUX: begin
        eng_len = 3'd3;
        eng_tx  = {OP_WREG | REG_MUX, OP_NOP, 8'(cur_ch_q), 8'h00};
      end
      S_GO:   eng_tx = {OP_START, 24'h0};
      S_RD: begin
        eng_len = 3'd4;
        eng_tx  = {OP_RDATA, OP_NOP, OP_NOP, OP_NOP};
      end
      S_HALT: eng_tx = {OP_STOP, 24'h0};
      default: is_xfer = 1'b0;
    endcase
  end

  assign eng_start = is_xfer && !launched_q;
  assign accept    = (state_q == S_IDLE) && scan_trig_i;
  assign store     = (state_q == S_RD) && eng_done;
  assign frame_end = (state_q == S_NEXT) && !pick_found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= USE_RST_PIN ? S_RPIN : S_RCMD;
      pin_q      <= !USE_RST_PIN;
      rcnt_q     <= '0;
      launched_q <= 1'b0;
      mask_q     <= '0;
      cur_ch_q   <= '0;
      slot_q     <= '0;
      valid_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (eng_start) launched_q <= 1'b1;
      else if (eng_done) launched_q <= 1'b0;
      case (state_q)
        S_RPIN: if (rcnt_q == RCNT_W'(RST_LOW_CYC)) begin
          pin_q   <= 1'b1;
          state_q <= S_IDLE;
        end else rcnt_q <= rcnt_q + 1'b1;
        S_RCMD: if (eng_done) state_q <= S_IDLE;
        S_IDLE: if (scan_trig_i) begin
          mask_q  <= scan_mask_i;
          slot_q  <= '0;
          state_q <= S_NEXT;
        end
        S_NEXT: if (!pick_found) begin
          valid_q <= 1'b1;
          state_q <= S_IDLE;
        end else begin
          cur_ch_q         <= pick_idx;
          mask_q[pick_idx] <= 1'b0;
          state_q          <= S_MUX;
        end
        S_MUX:  if (eng_done) state_q <= S_GO;
        S_GO:   if (eng_done) state_q <= S_RD;
        S_RD:   if (eng_done) begin
          slot_q  <= slot_q + 1'b1;
          state_q <= S_HALT;
        end
        S_HALT: if (eng_done) state_q <= S_NEXT;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // per-slot working buffer and published copy
  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic [31:0] buf_q, res_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_q <= '0;
        res_q <= '0;
      end else begin
        if (accept) buf_q <= '0;
        else if (store && (slot_q == SLOT_W'(g))) buf_q <= {8'h00, eng_rx};
        if (frame_end) res_q <= buf_q;
      end
    end
    assign res_data_o[32*g +: 32] = res_q;
  end

  assign busy_o      = (state_q != S_IDLE);
  assign adc_rst_no  = pin_q;
  assign res_valid_o = valid_q;

  a_r1_pin_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_rst_no |-> (busy_o && spi_cs_no));
  a_r8_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  a_r8_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> $stable(res_data_o));
  a_r10_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !busy_o);
  a_r3_slot_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store |-> (slot_q < SLOT_W'(NUM_CH)));
endmodule

// File: tb/adc_spi_dev_model.sv
`timescale 1ns/1ps
module adc_spi_dev_model (
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  logic [23:0] val [16];
  logic [31:0] fr_w [2048];
  int          fr_n [2048];
  int          nfr;
  logic [7:0]  cur;
  logic [31:0] acc;
  logic [23:0] sh;
  logic [3:0]  mux;
  logic        rd;
  int          bitc, bytec;

  initial begin
    nfr = 0; miso = 1'b0; mux = '0; rd = 1'b0;
    bitc = 0; bytec = 0; acc = '0; cur = '0; sh = '0;
    for (int i = 0; i < 16; i++) val[i] = '0;
  end

  always @(negedge cs_n) begin
    bitc = 0; bytec = 0; acc = '0; rd = 1'b0; miso = 1'b0;
  end

  always @(negedge sclk) begin
    if (!cs_n) begin
      cur  = {cur[6:0], mosi};
      bitc = bitc + 1;
      if (bitc == 8) begin
        bitc = 0;
        acc  = {acc[23:0], cur};
        if (bytec == 0 && cur == 8'h12) begin
          rd = 1'b1;
          sh = val[mux];
        end
        if (bytec == 2 && acc[23:16] == 8'h42 && acc[15:8] == 8'h00) mux = cur[3:0];
        bytec = bytec + 1;
      end
    end
  end

  always @(posedge sclk) begin
    if (!cs_n && rd && bytec >= 1) begin
      miso = sh[23];
      sh   = {sh[22:0], 1'b0};
    end
  end

  always @(posedge cs_n) begin
    if (bytec > 0 && nfr < 2048) begin
      fr_w[nfr] = acc;
      fr_n[nfr] = bytec;
      nfr = nfr + 1;
    end
  end
endmodule

// File: tb/tb_adc_scan_seq.sv
`timescale 1ns/1ps
module tb_adc_scan_seq;
  localparam int NA = 12, NB = 6, DIV = 2, GAP = 3, RLOW = 50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NA-1:0] mask_a = '0;
  logic [NB-1:0] mask_b = '0;
  logic trig_a = 1'b0, trig_b = 1'b0;
  logic busy_a, sclk_a, mosi_a, miso_a, cs_a, rstp_a, val_a;
  logic busy_b, sclk_b, mosi_b, miso_b, cs_b, rstp_b, val_b;
  logic [32*NA-1:0] res_a;
  logic [32*NB-1:0] res_b;
  int n_cmp = 0, n_bad = 0, cyc = 0, viol6 = 0, min_gap = 1000, gap_run = 1000;
  logic cs_prev = 1'b1;

  always #2.5 clk = ~clk;

  adc_scan_seq #(.NUM_CH(NA), .CLK_DIV(DIV), .CS_GAP(GAP), .RST_LOW_CYC(RLOW),
                 .USE_RST_PIN(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scan_mask_i(mask_a), .scan_trig_i(trig_a),
    .busy_o(busy_a), .spi_sclk_o(sclk_a), .spi_mosi_o(mosi_a), .spi_miso_i(miso_a),
    .spi_cs_no(cs_a), .adc_rst_no(rstp_a), .res_data_o(res_a), .res_valid_o(val_a));

  adc_scan_seq #(.NUM_CH(NB), .CLK_DIV(DIV), .CS_GAP(GAP), .RST_LOW_CYC(RLOW),
                 .USE_RST_PIN(1'b0)) dut_cmd (
    .clk_i(clk), .rst_ni(rst_n), .scan_mask_i(mask_b), .scan_trig_i(trig_b),
    .busy_o(busy_b), .spi_sclk_o(sclk_b), .spi_mosi_o(mosi_b), .spi_miso_i(miso_b),
    .spi_cs_no(cs_b), .adc_rst_no(rstp_b), .res_data_o(res_b), .res_valid_o(val_b));

  adc_spi_dev_model m_a (.sclk(sclk_a), .cs_n(cs_a), .mosi(mosi_a), .miso(miso_a));
  adc_spi_dev_model m_b (.sclk(sclk_b), .cs_n(cs_b), .mosi(mosi_b), .miso(miso_b));

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // bus monitors for R6 and R7, sampled after each edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst_n) begin
      if (cs_a && sclk_a) viol6++;
      if (cs_a) gap_run++;
      else if (cs_prev) begin
        if (gap_run < min_gap) min_gap = gap_run;
        gap_run = 0;
      end
    end
    cs_prev = cs_a;
    if (cyc > 180000) begin
      chk(1'b0, "WATCHDOG", 64'(cyc), 64'd180000);
      summary();
    end
  end

  task automatic rand_vals();
    for (int i = 0; i < 16; i++) begin
      m_a.val[i] = 24'($urandom);
      m_b.val[i] = 24'($urandom);
    end
  endtask

  task automatic wait_valid(input int which, output bit got);
    got = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      tick();
      if ((which == 0 && val_a) || (which == 1 && val_b)) begin
        got = 1'b1;
        break;
      end
    end
    chk(got, "R8 valid strobe seen", 64'(got), 64'd1);
    if (which == 0) chk(!busy_a, "R10 busy low at valid", 64'(busy_a), 64'd0);
    else chk(!busy_b, "R10 busy low at valid", 64'(busy_b), 64'd0);
  endtask

  // results and frame log against the mask, no time consumed
  task automatic check_scan(input int which, input logic [NA-1:0] m, input int base);
    int slot = 0, k = base, nch, nf;
    logic [31:0] w0, w1, w2, w3, got, exp;
    nch = (which == 0) ? NA : NB;
    for (int i = 0; i < nch; i++) begin
      if (m[i]) begin
        exp = (which == 0) ? {8'h00, m_a.val[i]} : {8'h00, m_b.val[i]};
        got = (which == 0) ? res_a[32*slot +: 32] : res_b[32*slot +: 32];
        chk(got == exp, "R3 R5 slot value", 64'(got), 64'(exp));
        if (which == 0) begin
          w0 = m_a.fr_w[k]; w1 = m_a.fr_w[k+1]; w2 = m_a.fr_w[k+2]; w3 = m_a.fr_w[k+3];
          nf = (m_a.fr_n[k] == 3 && m_a.fr_n[k+1] == 1 && m_a.fr_n[k+2] == 4 && m_a.fr_n[k+3] == 1) ? 1 : 0;
        end else begin
          w0 = m_b.fr_w[k]; w1 = m_b.fr_w[k+1]; w2 = m_b.fr_w[k+2]; w3 = m_b.fr_w[k+3];
          nf = (m_b.fr_n[k] == 3 && m_b.fr_n[k+1] == 1 && m_b.fr_n[k+2] == 4 && m_b.fr_n[k+3] == 1) ? 1 : 0;
        end
        chk(nf == 1 && w0[23:0] == {16'h4200, 8'(i)} && w1[7:0] == 8'h08 &&
            w2 == 32'h1200_0000 && w3[7:0] == 8'h0A, "R4 frame sequence",
            {w0[23:0], w1[7:0], w3[7:0], 24'(nf)}, {16'h4200, 8'(i), 8'h08, 8'h0A, 24'd1});
        slot++;
        k += 4;
      end
    end
    for (int s = slot; s < nch; s++) begin
      got = (which == 0) ? res_a[32*s +: 32] : res_b[32*s +: 32];
      chk(got == 32'h0, "R3 unused slot zero", 64'(got), 64'd0);
    end
    nf = ((which == 0) ? m_a.nfr : m_b.nfr) - base;
    chk(nf == 4 * slot, "R4 R11 frame count", 64'(nf), 64'(4 * slot));
  endtask

  task automatic run_scan_a(input logic [NA-1:0] m);
    int base;
    bit got;
    logic [32*NA-1:0] snap;
    rand_vals();
    base = m_a.nfr;
    @(negedge clk); mask_a = m; trig_a = 1'b1;
    @(negedge clk); trig_a = 1'b0;
    chk(busy_a, "R12 busy after trigger", 64'(busy_a), 64'd1);
    wait_valid(0, got);
    check_scan(0, m, base);
    snap = res_a;
    tick(); tick();
    chk(!val_a, "R8 single pulse", 64'(val_a), 64'd0);
    chk(res_a == snap, "R8 data held", 64'(res_a), 64'(snap));
  endtask

  initial begin
    int lowcnt = 0, base, nf;
    bit cs_low = 1'b0, pinb_low = 1'b0, got;
    logic [NA-1:0] m2;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    chk(busy_a && cs_a && !val_a && !rstp_a && res_a == '0, "R1 R8 reset state",
        {busy_a, cs_a, val_a, rstp_a}, 64'b1100);
    // boot; triggers held during it must be ignored (R9)
    @(negedge clk); rst_n = 1'b1; mask_a = '1; trig_a = 1'b1; mask_b = '1; trig_b = 1'b1;
    for (int i = 0; i < RLOW + 40; i++) begin
      tick();
      if (!rstp_a) lowcnt++;
      if (!cs_a) cs_low = 1'b1;
      if (!rstp_b) pinb_low = 1'b1;
      if (i == 3) trig_b = 1'b0;
      if (i == RLOW - 10) trig_a = 1'b0;
    end
    chk(lowcnt == RLOW, "R1 reset pin low cycles", 64'(lowcnt), 64'(RLOW));
    chk(!cs_low, "R1 no SPI during pin reset", 64'(cs_low), 64'd0);
    chk(!busy_a && m_a.nfr == 0 && !val_a, "R9 boot trigger ignored", 64'(m_a.nfr), 64'd0);
    chk(!pinb_low, "R2 pin unused in command mode", 64'(pinb_low), 64'd0);
    chk(m_b.nfr == 1 && m_b.fr_n[0] == 1 && m_b.fr_w[0][7:0] == 8'h06,
        "R2 reset command frame", {32'(m_b.nfr), m_b.fr_w[0]}, {32'd1, 32'h06});
    chk(!busy_b, "R12 command boot finished", 64'(busy_b), 64'd0);

    // directed then random masks
    run_scan_a(12'h001);
    run_scan_a(12'h800);
    run_scan_a(12'hFFF);
    run_scan_a(12'hA5A);
    run_scan_a(12'h000);   // R11 empty mask
    for (int r = 0; r < 8; r++) run_scan_a(12'($urandom));

    // R9: trigger during a running scan
    rand_vals();
    base = m_a.nfr;
    @(negedge clk); mask_a = 12'h003; trig_a = 1'b1;
    @(negedge clk); trig_a = 1'b0;
    repeat (50) @(negedge clk);
    mask_a = 12'hFFF; trig_a = 1'b1;
    @(negedge clk); trig_a = 1'b0;
    wait_valid(0, got);
    check_scan(0, 12'h003, base);
    nf = m_a.nfr;
    got = 1'b0;
    for (int i = 0; i < 300; i++) begin
      tick();
      if (val_a || busy_a) got = 1'b1;
    end
    chk(!got && m_a.nfr == nf, "R9 busy trigger ignored", 64'(m_a.nfr), 64'(nf));

    // R10: new trigger in the cycle of the valid strobe
    rand_vals();
    base = m_a.nfr;
    @(negedge clk); mask_a = 12'h010; trig_a = 1'b1;
    @(negedge clk); trig_a = 1'b0;
    wait_valid(0, got);
    check_scan(0, 12'h010, base);
    base = m_a.nfr;
    m2 = 12'h101;
    mask_a = m2; trig_a = 1'b1;
    tick();
    trig_a = 1'b0;
    chk(busy_a, "R10 trigger at valid accepted", 64'(busy_a), 64'd1);
    wait_valid(0, got);
    check_scan(0, m2, base);

    // six-channel command-reset variant
    rand_vals();
    base = m_b.nfr;
    @(negedge clk); mask_b = 6'b101001; trig_b = 1'b1;
    @(negedge clk); trig_b = 1'b0;
    wait_valid(1, got);
    check_scan(1, 12'(6'b101001), base);

    chk(viol6 == 0, "R6 sclk idle low", 64'(viol6), 64'd0);
    chk(min_gap >= GAP, "R7 chip-select gap", 64'(min_gap), 64'(GAP));
    summary();
  end
endmodule